// File: doc/BRIEF.md
# RTC Configuration Write Guard

This block is the control front end of a real-time-clock peripheral. It keeps the clock's configuration registers locked until software writes a two-byte key, and it runs the request/acknowledge handshake that stops the slow clock-domain counters before any timing-critical setting is changed. The block sits on a simple single-cycle register bus in the bus clock domain. It passes a stop request into the RTC clock domain and returns an acknowledge.

Software unlocks the block with the key bytes 0xCA and then 0x53. It sets the INIT request and waits for the acknowledge, which arrives a few slow-clock cycles later. It then writes the prescaler and the hour-format bit and clears INIT. It relocks by writing any other key value. The output-select and polarity fields need only the unlock. The block also drives a gate, `cal_wr_allow`, that the calendar registers outside it use for their own writes.

Top module: `rtc_cfg_guard`

## Requirements
- R1: After reset the block is locked. INIT and the acknowledge are 0 and `counters_run` is 1. The synchronous divider is 255, the asynchronous divider is 127, the format bit is 0 (24-hour), the output select is 0 (disabled) and the polarity is 0 (active-high).
- R2: A key write (address 0) with low byte 0xCA, followed by a key write with low byte 0x53, raises `unlocked` in the cycle after the second write. Writes to other addresses between the two key writes do not break the sequence.
- R3: Any key write while unlocked drops `unlocked` in the next cycle. If the value written is 0xCA, it also counts as a new first key.
- R4: A first key other than 0xCA, or a second key other than 0x53, leaves the block locked. The sequence then starts again from the first key.
- R5: A write to the control register (address 1, bit 0 = INIT) takes effect only while unlocked. While locked it is dropped and INIT keeps its value.
- R6: INIT passes through two RTC-clock flops and one stop flop. `counters_run` falls on the third RTC edge after INIT rises, and `init_ack` rises two bus edges after that. Clearing INIT reverses both signals with the same delays.
- R7: The prescaler register (address 2: synchronous divider in bits [14:0], asynchronous divider in bits [21:15]) changes only on a write made while both `unlocked` and `init_ack` are high. Any other write leaves both fields unchanged.
- R8: At the configuration register (address 3), bit 0 is the format, bits [2:1] are the output select and bit 3 is the polarity. The select and polarity need only `unlocked`. The format bit also needs `init_ack`.
- R9: `rd_data` shows the register at `rd_addr` one cycle later. Address 0 reads 0. Address 1 reads {ack, INIT} in bits [1:0]. Address 2 reads the prescaler in its write layout. Address 3 reads the configuration in its write layout.
- R10: `cal_wr_allow` is high exactly when the block is unlocked and `init_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| rtc_clk | input | 1 | Slow RTC clock |
| rtc_rst | input | 1 | Synchronous active-high reset, RTC domain |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | SYNC_W+ASYNC_W | Write data |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | SYNC_W+ASYNC_W | Registered read data |
| unlocked | output | 1 | Protected registers writable |
| init_ack | output | 1 | Counters stopped, seen in bus domain |
| cal_wr_allow | output | 1 | Write gate for external calendar registers |
| counters_run | output | 1 | RTC-domain counter enable |
| sync_div | output | SYNC_W | Synchronous prescaler value |
| async_div | output | ASYNC_W | Asynchronous prescaler value |
| fmt_12h | output | 1 | Hour format, 1 selects 12-hour |
| out_sel | output | OSEL_W | Output-select field |
| out_pol | output | 1 | Output polarity, 1 selects active-low |

## Verification
The bench targets four corner cases:

- **Bad key bytes.** It sends a wrong second key, and a 0xCA straight after a wrong key. A design that failed to reset its sequence would unlock on a stray 0x53.
- **Interleaved writes.** It places non-key writes between the two key bytes. A design that treated those writes as breaking the sequence would stay locked.
- **The window before the acknowledge.** It writes the prescaler and format after INIT is set but before the acknowledge arrives. A design that gated on INIT rather than the acknowledge would accept those writes early.
- **Relocking and mixed gates.** It relocks with 0xCA and checks that the output select and polarity update without the acknowledge while the format bit does not. Random traffic is compared on every cycle against a behavioural model of both clock domains.

// File: rtl/rtc_guard_pkg.sv
package rtc_guard_pkg;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_FIRST  = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_t;

  localparam int unsigned REG_KEY   = 0;
  localparam int unsigned REG_CTRL  = 1;
  localparam int unsigned REG_PRESC = 2;
  localparam int unsigned REG_CFG   = 3;

  localparam logic [7:0] KEY_FIRST  = 8'hCA;
  localparam logic [7:0] KEY_SECOND = 8'h53;

endpackage

// File: rtl/rtc_key_seq.sv
module rtc_key_seq
  import rtc_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_we,
  input  logic [7:0] key_byte,
  output logic       unlocked
);

  key_state_t state_q, state_d;

  // Only key writes advance or reset the sequence (R2, R3, R4)
  always_comb begin
    state_d = state_q;
    if (key_we) begin
      case (state_q)
        KS_FIRST: state_d = (key_byte == KEY_SECOND) ? KS_OPEN : KS_LOCKED;
        default:  state_d = (key_byte == KEY_FIRST)  ? KS_FIRST : KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= KS_LOCKED;
      unlocked <= 1'b0;
    end else begin
      state_q  <= state_d;
      unlocked <= (state_d == KS_OPEN);
    end
  end

endmodule

// File: rtl/rtc_init_xing.sv
module rtc_init_xing #(
  parameter int STAGES = 2
) (
  input  logic bus_clk,
  input  logic bus_rst,
  input  logic rtc_clk,
  input  logic rtc_rst,
  input  logic init_req,
  output logic init_ack,
  output logic counters_run
);

  logic [STAGES-1:0] req_sync_q;
  logic              stopped_q;
  logic [STAGES-1:0] ack_sync_q;

  // Request into the slow domain, then one flop that stops the counters (R6)
  always_ff @(posedge rtc_clk) begin
    if (rtc_rst) begin
      req_sync_q <= '0;
      stopped_q  <= 1'b0;
    end else begin
      req_sync_q <= {req_sync_q[STAGES-2:0], init_req};
      stopped_q  <= req_sync_q[STAGES-1];
    end
  end

  assign counters_run = ~stopped_q;

  // Stop flag back into the bus domain
  always_ff @(posedge bus_clk) begin
    if (bus_rst) begin
      ack_sync_q <= '0;
    end else begin
      ack_sync_q <= {ack_sync_q[STAGES-2:0], stopped_q};
    end
  end

  assign init_ack = ack_sync_q[STAGES-1];

endmodule

// File: rtl/rtc_cfg_file.sv
module rtc_cfg_file
  import rtc_guard_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int SYNC_W    = 15,
  parameter int ASYNC_W   = 7,
  parameter int OSEL_W    = 2,
  parameter int SYNC_RST  = 255,
  parameter int ASYNC_RST = 127,
  parameter int DATA_W    = SYNC_W + ASYNC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic               unlocked,
  input  logic               init_ack,
  output logic               init_req,
  output logic [SYNC_W-1:0]  sync_div,
  output logic [ASYNC_W-1:0] async_div,
  output logic               fmt_12h,
  output logic [OSEL_W-1:0]  out_sel,
  output logic               out_pol,
  output logic [DATA_W-1:0]  rd_data
);

  localparam int FMT_BIT  = 0;
  localparam int OSEL_LSB = 1;
  localparam int POL_BIT  = OSEL_LSB + OSEL_W;

  logic wr_ctrl, wr_presc, wr_cfg;
  logic [DATA_W-1:0] rd_word;

  assign wr_ctrl  = wr_en && (wr_addr == ADDR_W'(REG_CTRL))  && unlocked;
  assign wr_presc = wr_en && (wr_addr == ADDR_W'(REG_PRESC)) && unlocked && init_ack;
  assign wr_cfg   = wr_en && (wr_addr == ADDR_W'(REG_CFG))   && unlocked;

  always_comb begin
    rd_word = '0;
    case (rd_addr)
      ADDR_W'(REG_CTRL): begin
        rd_word[0] = init_req;
        rd_word[1] = init_ack;
      end
      ADDR_W'(REG_PRESC): rd_word = {async_div, sync_div};
      ADDR_W'(REG_CFG): begin
        rd_word[FMT_BIT]              = fmt_12h;
        rd_word[OSEL_LSB +: OSEL_W]   = out_sel;
        rd_word[POL_BIT]              = out_pol;
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_req  <= 1'b0;
      sync_div  <= SYNC_W'(SYNC_RST);
      async_div <= ASYNC_W'(ASYNC_RST);
      fmt_12h   <= 1'b0;
      out_sel   <= '0;
      out_pol   <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_data <= rd_word;
      if (wr_ctrl) begin
        init_req <= wr_data[0];
      end
      if (wr_presc) begin
        sync_div  <= wr_data[SYNC_W-1:0];
        async_div <= wr_data[SYNC_W +: ASYNC_W];
      end
      if (wr_cfg) begin
        out_sel <= wr_data[OSEL_LSB +: OSEL_W];
        out_pol <= wr_data[POL_BIT];
        if (init_ack) begin
          fmt_12h <= wr_data[FMT_BIT];
        end
      end
    end
  end

endmodule

// File: rtl/rtc_cfg_guard.sv
module rtc_cfg_guard
  import rtc_guard_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int SYNC_W      = 15,
  parameter int ASYNC_W     = 7,
  parameter int OSEL_W      = 2,
  parameter int SYNC_RST    = 255,
  parameter int ASYNC_RST   = 127,
  parameter int XING_STAGES = 2,
  localparam int DATA_W     = SYNC_W + ASYNC_W
) (
  input  logic               bus_clk,
  input  logic               bus_rst,
  input  logic               rtc_clk,
  input  logic               rtc_rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               unlocked,
  output logic               init_ack,
  output logic               cal_wr_allow,
  output logic               counters_run,
  output logic [SYNC_W-1:0]  sync_div,
  output logic [ASYNC_W-1:0] async_div,
  output logic               fmt_12h,
  output logic [OSEL_W-1:0]  out_sel,
  output logic               out_pol
);

  logic key_we;
  logic init_req;

  assign key_we = wr_en && (wr_addr == ADDR_W'(REG_KEY));

  rtc_key_seq u_key (
    .clk      (bus_clk),
    .rst      (bus_rst),
    .key_we   (key_we),
    .key_byte (wr_data[7:0]),
    .unlocked (unlocked)
  );

  rtc_init_xing #(
    .STAGES (XING_STAGES)
  ) u_xing (
    .bus_clk      (bus_clk),
    .bus_rst      (bus_rst),
    .rtc_clk      (rtc_clk),
    .rtc_rst      (rtc_rst),
    .init_req     (init_req),
    .init_ack     (init_ack),
    .counters_run (counters_run)
  );

  rtc_cfg_file #(
    .ADDR_W    (ADDR_W),
    .SYNC_W    (SYNC_W),
    .ASYNC_W   (ASYNC_W),
    .OSEL_W    (OSEL_W),
    .SYNC_RST  (SYNC_RST),
    .ASYNC_RST (ASYNC_RST),
    .DATA_W    (DATA_W)
  ) u_regs (
    .clk       (bus_clk),
    .rst       (bus_rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .unlocked  (unlocked),
    .init_ack  (init_ack),
    .init_req  (init_req),
    .sync_div  (sync_div),
    .async_div (async_div),
    .fmt_12h   (fmt_12h),
    .out_sel   (out_sel),
    .out_pol   (out_pol),
    .rd_data   (rd_data)
  );

  // Gate for calendar registers kept outside this block (R10)
  assign cal_wr_allow = unlocked & init_ack;

endmodule

// File: rtl/rtc_cfg_guard_chk.sv
module rtc_cfg_guard_chk
  import rtc_guard_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int SYNC_W  = 15,
  parameter int ASYNC_W = 7,
  parameter int OSEL_W  = 2
) (
  input logic               bus_clk,
  input logic               bus_rst,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [7:0]         key_byte,
  input logic               unlocked,
  input logic               init_ack,
  input logic               cal_wr_allow,
  input logic [SYNC_W-1:0]  sync_div,
  input logic [ASYNC_W-1:0] async_div,
  input logic               fmt_12h,
  input logic [OSEL_W-1:0]  out_sel,
  input logic               out_pol
);

  p_open_after_second_key_r2: assert property (@(posedge bus_clk) disable iff (bus_rst)
    $rose(unlocked) |-> $past(wr_en && (wr_addr == ADDR_W'(REG_KEY)) && (key_byte == KEY_SECOND)));

  p_relock_on_key_r3: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (unlocked && wr_en && (wr_addr == ADDR_W'(REG_KEY))) |=> !unlocked);

  p_presc_held_r7: assert property (@(posedge bus_clk) disable iff (bus_rst)
    !cal_wr_allow |=> ($stable(sync_div) && $stable(async_div)));

  p_cfg_held_locked_r8: assert property (@(posedge bus_clk) disable iff (bus_rst)
    !unlocked |=> ($stable(out_sel) && $stable(out_pol) && $stable(fmt_12h)));

  p_fmt_needs_ack_r8: assert property (@(posedge bus_clk) disable iff (bus_rst)
    !init_ack |=> $stable(fmt_12h));

endmodule

bind rtc_cfg_guard rtc_cfg_guard_chk #(
  .ADDR_W  (ADDR_W),
  .SYNC_W  (SYNC_W),
  .ASYNC_W (ASYNC_W),
  .OSEL_W  (OSEL_W)
) u_chk (
  .bus_clk      (bus_clk),
  .bus_rst      (bus_rst),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .key_byte     (wr_data[7:0]),
  .unlocked     (unlocked),
  .init_ack     (init_ack),
  .cal_wr_allow (cal_wr_allow),
  .sync_div     (sync_div),
  .async_div    (async_div),
  .fmt_12h      (fmt_12h),
  .out_sel      (out_sel),
  .out_pol      (out_pol)
);

// File: tb/rtc_cfg_guard_test.sv
`timescale 1ns/100ps
module rtc_cfg_guard_test;

  logic        bus_clk = 1'b0;
  logic        rtc_clk = 1'b0;
  logic        bus_rst = 1'b1;
  logic        rtc_rst = 1'b1;
  logic        wr_en   = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [21:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [21:0] rd_data;
  logic        unlocked, init_ack, cal_wr_allow, counters_run;
  logic [14:0] sync_div;
  logic [6:0]  async_div;
  logic        fmt_12h, out_pol;
  logic [1:0]  out_sel;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  rtc_cfg_guard uut (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .rtc_clk(rtc_clk), .rtc_rst(rtc_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .unlocked(unlocked), .init_ack(init_ack),
    .cal_wr_allow(cal_wr_allow), .counters_run(counters_run),
    .sync_div(sync_div), .async_div(async_div), .fmt_12h(fmt_12h),
    .out_sel(out_sel), .out_pol(out_pol)
  );

  // 200 MHz bus clock; RTC edges never coincide with bus edges
  always #2.5 bus_clk = ~bus_clk;
  initial begin
    #1.3;
    forever #11 rtc_clk = ~rtc_clk;
  end

  // ---------------- behavioural reference model ----------------
  int          m_ks;
  logic        m_unl, m_init, m_b1, m_b2;
  logic [14:0] m_sync;
  logic [6:0]  m_async;
  logic        m_fmt, m_pol;
  logic [1:0]  m_osel;
  logic [21:0] m_rd;
  logic        m_r1, m_r2, m_rf;
  logic        o_unl, o_ack;

  always @(posedge bus_clk) begin
    if (bus_rst) begin
      m_ks = 0; m_unl = 0; m_init = 0; m_b1 = 0; m_b2 = 0;
      m_sync = 15'd255; m_async = 7'd127; m_fmt = 0; m_osel = 0; m_pol = 0;
      m_rd = 0;
    end else begin
      o_unl = m_unl;
      o_ack = m_b2;
      case (rd_addr)
        2'd1:    m_rd = 22'({o_ack, m_init});
        2'd2:    m_rd = {m_async, m_sync};
        2'd3:    m_rd = 22'({m_pol, m_osel, m_fmt});
        default: m_rd = 0;
      endcase
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            if (m_ks == 1) m_ks = (wr_data[7:0] == 8'h53) ? 2 : 0;
            else           m_ks = (wr_data[7:0] == 8'hCA) ? 1 : 0;
          end
          2'd1: if (o_unl) m_init = wr_data[0];
          2'd2: if (o_unl && o_ack) begin
            m_sync  = wr_data[14:0];
            m_async = wr_data[21:15];
          end
          default: if (o_unl) begin
            m_osel = wr_data[2:1];
            m_pol  = wr_data[3];
            if (o_ack) m_fmt = wr_data[0];
          end
        endcase
      end
      m_unl = (m_ks == 2);
      m_b2 = m_b1;
      m_b1 = m_rf;
    end
  end

  always @(posedge rtc_clk) begin
    if (rtc_rst) begin
      m_r1 = 0; m_r2 = 0; m_rf = 0;
    end else begin
      m_rf = m_r2;
      m_r2 = m_r1;
      m_r1 = m_init;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge bus_clk) begin
    if (!bus_rst && !done) begin
      chk("R2/R3/R4 unlocked", 32'(unlocked), 32'(m_unl));
      chk("R6 init_ack", 32'(init_ack), 32'(m_b2));
      chk("R10 cal_wr_allow", 32'(cal_wr_allow), 32'(m_unl & m_b2));
      chk("R7 sync_div", 32'(sync_div), 32'(m_sync));
      chk("R7 async_div", 32'(async_div), 32'(m_async));
      chk("R8 fmt_12h", 32'(fmt_12h), 32'(m_fmt));
      chk("R8 out_sel", 32'(out_sel), 32'(m_osel));
      chk("R8 out_pol", 32'(out_pol), 32'(m_pol));
      chk("R9 rd_data", 32'(rd_data), 32'(m_rd));
    end
  end

  always @(negedge rtc_clk) begin
    if (!rtc_rst && !done) chk("R6 counters_run", 32'(counters_run), 32'(!m_rf));
  end

  // Watchdog
  always @(posedge bus_clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [21:0] d);
    @(negedge bus_clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge bus_clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge bus_clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [21:0] d);
    @(negedge bus_clk);
    rd_addr = a;
    @(negedge bus_clk);
    d = rd_data;
  endtask

  task automatic wait_ack(input logic v);
    for (int i = 0; i < 60; i++) begin
      if (init_ack === v) break;
      @(negedge bus_clk);
    end
  endtask

  logic [21:0] rv;

  initial begin
    idle(20);
    bus_rst = 0;
    rtc_rst = 0;
    idle(2);
    // R1 reset state
    chk("R1 unlocked", 32'(unlocked), 0);
    chk("R1 init_ack", 32'(init_ack), 0);
    chk("R1 counters_run", 32'(counters_run), 1);
    chk("R1 sync_div", 32'(sync_div), 255);
    chk("R1 async_div", 32'(async_div), 127);
    chk("R1 fmt/sel/pol", 32'({fmt_12h, out_sel, out_pol}), 0);

    // locked writes are dropped
    wr(2'd2, 22'h3FFFFF);
    wr(2'd3, 22'hF);
    wr(2'd1, 22'h1);
    idle(40);
    chk("R7 presc while locked", 32'(sync_div), 255);
    chk("R8 sel while locked", 32'(out_sel), 0);
    chk("R5 INIT while locked", 32'(init_ack), 0);
    rd(2'd1, rv);
    chk("R5 ctrl readback locked", 32'(rv), 0);

    // unlock / relock / bad keys
    wr(2'd0, 22'hCA); wr(2'd0, 22'h53);
    chk("R2 unlock", 32'(unlocked), 1);
    wr(2'd0, 22'hFF);
    chk("R3 relock", 32'(unlocked), 0);
    wr(2'd0, 22'h11); wr(2'd0, 22'h53);
    chk("R4 wrong first key", 32'(unlocked), 0);
    wr(2'd0, 22'hCA); wr(2'd0, 22'h99); wr(2'd0, 22'h53);
    chk("R4 wrong second key", 32'(unlocked), 0);
    wr(2'd0, 22'h99); wr(2'd0, 22'hCA); wr(2'd3, 22'h6); wr(2'd0, 22'h53);
    chk("R2 interleaved unlock", 32'(unlocked), 1);
    chk("R8 cfg write while locked", 32'(out_sel), 0);

    // INIT handshake; writes before ack
    wr(2'd1, 22'h1);
    wr(2'd2, 22'h5555);
    wr(2'd3, 22'hD);
    chk("R7 presc before ack", 32'(sync_div), 255);
    chk("R8 sel without ack", 32'(out_sel), 2);
    chk("R8 pol without ack", 32'(out_pol), 1);
    chk("R8 fmt before ack", 32'(fmt_12h), 0);
    wait_ack(1);
    chk("R6 ack raised", 32'(init_ack), 1);
    chk("R6 counters stopped", 32'(counters_run), 0);
    chk("R10 gate open", 32'(cal_wr_allow), 1);
    wr(2'd2, (22'h42 << 15) | 22'h123);
    chk("R7 sync written", 32'(sync_div), 32'h123);
    chk("R7 async written", 32'(async_div), 32'h42);
    wr(2'd3, 22'hD);
    chk("R8 fmt written", 32'(fmt_12h), 1);
    rd(2'd2, rv);
    chk("R9 presc read", 32'(rv), 32'((22'h42 << 15) | 22'h123));
    rd(2'd1, rv);
    chk("R9 ctrl read", 32'(rv), 3);
    rd(2'd3, rv);
    chk("R9 cfg read", 32'(rv), 32'hD);

    wr(2'd1, 22'h0);
    wait_ack(0);
    idle(2);
    chk("R6 ack cleared", 32'(init_ack), 0);
    chk("R6 counters resume", 32'(counters_run), 1);
    chk("R10 gate closed", 32'(cal_wr_allow), 0);
    wr(2'd2, 22'h7);
    chk("R7 presc after clear", 32'(sync_div), 32'h123);

    // relock with 0xCA counts as a fresh first key
    wr(2'd0, 22'hCA);
    chk("R3 relock by CA", 32'(unlocked), 0);
    wr(2'd0, 22'h53);
    chk("R3 CA restarts sequence", 32'(unlocked), 1);
    wr(2'd0, 22'h00);
    wr(2'd1, 22'h1);
    idle(40);
    chk("R5 INIT ignored relocked", 32'(init_ack), 0);

    // random traffic, checked every cycle by the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge bus_clk);
      wr_en   = ($urandom_range(0, 1) == 1);
      wr_addr = 2'($urandom_range(0, 3));
      wr_data = 22'($urandom);
      if (wr_addr == 2'd0) begin
        case ($urandom_range(0, 3))
          0: wr_data[7:0] = 8'hCA;
          1: wr_data[7:0] = 8'h53;
          default: ;
        endcase
      end
      rd_addr = 2'($urandom_range(0, 3));
    end
    @(negedge bus_clk);
    wr_en = 0;
    idle(10);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule